// File: doc/BRIEF.md
# Two-Way Set-Associative Tag Directory

This block keeps the tags and the coherence states for a small cache. The cache has 16 sets and 2 ways, so it holds 32 lines of 256 bytes, each aligned on a 256-byte boundary. A lookup port returns in the same cycle whether a 32-bit physical address is present, which way holds it and that line's 2-bit coherence state. A line counts as present only when its state is not Invalid. A strobe on the lookup port marks a real access. When that access hits, the set's recency bit is updated.

A fill port gives the way into which a new line should go. The same cycle it reports whether the line being displaced is Modified and so needs a writeback, together with that line's tag. On the next clock edge it records the new tag and state. A third port lets a coherence controller write a new state into any set and way in one cycle. The data array, the memory side and the coherence messaging are outside this block.

Top module: `tag_dir`

## Requirements
- R1: After reset every line is Invalid, so any lookup misses (lk_hit_o=0, lk_state_o=00).
- R2: The set index is address bits [11:8] and the tag is bits [31:12]. Bits [7:0] do not affect a lookup, and a matching tag in another set does not hit.
- R3: A lookup hits only when a way of the indexed set holds the same tag and a state other than Invalid. It returns that way and its state, encoded 00 Invalid, 01 Shared, 10 Exclusive, 11 Modified. On a miss lk_state_o is 00.
- R4: A fill of an absent address picks an Invalid way, and way 0 when both ways are Invalid.
- R5: Each set has one recency bit that names the way to evict. A fill, or a lookup hit with lk_valid_i high, sets it to the other way. When both ways are occupied, a fill of an absent address uses the named way. If a fill and a lookup update the same set in one cycle, the fill's value wins.
- R6: fill_wb_o is 1 exactly when the chosen way is displaced and its state is Modified (11). fill_victim_tag_o then gives that line's tag. Exclusive or Shared victims give fill_wb_o=0.
- R7: A fill of an address already present reuses the way that holds it, with fill_wb_o=0, so a tag never sits in both ways of one set.
- R8: An update command writes upd_state_i into the entry at upd_set_i and upd_way_i on the next clock edge and leaves its tag unchanged.
- R9: If a fill and an update target the same entry in one cycle, the fill's state is kept. An update to a different entry in that cycle still takes effect.
- R10: After a fill, the new tag and state are visible to a lookup from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Lookup is a real access; a hit updates the recency bit |
| lk_addr_i | input | 32 | Lookup physical address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_way_o | output | 1 | Way that hit |
| lk_state_o | output | 2 | State of the hit line, 00 on a miss |
| fill_valid_i | input | 1 | Fill request, committed at the clock edge |
| fill_addr_i | input | 32 | Fill physical address |
| fill_state_i | input | 2 | State written with the filled line |
| fill_way_o | output | 1 | Way chosen for the fill |
| fill_wb_o | output | 1 | Displaced line is Modified and needs a writeback |
| fill_victim_tag_o | output | 20 | Tag of the displaced line |
| upd_valid_i | input | 1 | State update command |
| upd_set_i | input | 4 | Set to update |
| upd_way_i | input | 1 | Way to update |
| upd_state_i | input | 2 | New state |

## Verification
On every cycle the assertions check the following. Neither lookup path sees a tag hit in both ways. A writeback flag only comes with a fully occupied set. An absent fill with a free way lands on an Invalid way. Each committed fill or update leaves exactly the written tag, state and recency bit in storage. The bench sweeps all 16 sets against an arithmetic model of the directory. That sweep shows what the per-cycle checks cannot: victim order under different recency histories, that offset bits and other sets are ignored, that Invalid lines never hit, and how a fill and an update in the same cycle resolve.

// File: rtl/tag_dir_pkg.sv
package tag_dir_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_state_e;
endpackage

// File: rtl/tag_dir_lookup.sv
module tag_dir_lookup #(
  parameter int TAG_W = 20
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [TAG_W-1:0]           tag_i,
  input  logic [1:0][TAG_W-1:0]      way_tag_i,
  input  logic [1:0][1:0]            way_st_i,
  output logic                       hit_o,
  output logic                       way_o
);
  import tag_dir_pkg::*;

  logic [1:0] hit_vec;

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign hit_vec[w] = (way_st_i[w] != ST_I) && (way_tag_i[w] == tag_i);
  end

  assign hit_o = |hit_vec;
  assign way_o = hit_vec[1];

  // fill reuse keeps a tag in one way only
  assert_no_dup_tag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

// File: rtl/tag_dir_victim.sv
module tag_dir_victim #(
  parameter int TAG_W = 20
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [1:0][TAG_W-1:0]      way_tag_i,
  input  logic [1:0][1:0]            way_st_i,
  input  logic                       lru_i,
  input  logic                       hit_i,
  input  logic                       hit_way_i,
  output logic                       way_o,
  output logic                       wb_o,
  output logic [TAG_W-1:0]           vtag_o
);
  import tag_dir_pkg::*;

  logic [1:0] free_vec;

  for (genvar w = 0; w < 2; w++) begin : g_free
    assign free_vec[w] = (way_st_i[w] == ST_I);
  end

  always_comb begin
    if (hit_i)            way_o = hit_way_i;
    else if (free_vec[0]) way_o = 1'b0;
    else if (free_vec[1]) way_o = 1'b1;
    else                  way_o = lru_i;
  end

  assign wb_o   = !hit_i && (way_st_i[way_o] == ST_M);
  assign vtag_o = way_tag_i[way_o];

  assert_wb_full_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_o |-> (way_st_i[0] != ST_I && way_st_i[1] != ST_I));

  assert_free_way_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i && (|free_vec)) |-> (way_st_i[way_o] == ST_I));
endmodule

// File: rtl/tag_dir.sv
module tag_dir #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 8,
  parameter int SET_W  = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         lk_valid_i,
  input  logic [ADDR_W-1:0]            lk_addr_i,
  output logic                         lk_hit_o,
  output logic                         lk_way_o,
  output logic [1:0]                   lk_state_o,
  input  logic                         fill_valid_i,
  input  logic [ADDR_W-1:0]            fill_addr_i,
  input  logic [1:0]                   fill_state_i,
  output logic                         fill_way_o,
  output logic                         fill_wb_o,
  output logic [ADDR_W-OFF_W-SET_W-1:0] fill_victim_tag_o,
  input  logic                         upd_valid_i,
  input  logic [SET_W-1:0]             upd_set_i,
  input  logic                         upd_way_i,
  input  logic [1:0]                   upd_state_i
);
  import tag_dir_pkg::*;

  localparam int TAG_W = ADDR_W - OFF_W - SET_W;
  localparam int SETS  = 1 << SET_W;
  localparam int WAYS  = 2;

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  line_state_e      st_q  [SETS][WAYS];
  logic             lru_q [SETS];

  logic [SET_W-1:0] lk_set, fill_set;
  logic [TAG_W-1:0] lk_tag, fill_tag;

  assign lk_set   = lk_addr_i[OFF_W +: SET_W];
  assign lk_tag   = lk_addr_i[ADDR_W-1 -: TAG_W];
  assign fill_set = fill_addr_i[OFF_W +: SET_W];
  assign fill_tag = fill_addr_i[ADDR_W-1 -: TAG_W];

  logic [1:0][TAG_W-1:0] lk_way_tag, fill_way_tag;
  logic [1:0][1:0]       lk_way_st,  fill_way_st;

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign lk_way_tag[w]   = tag_q[lk_set][w];
    assign lk_way_st[w]    = st_q[lk_set][w];
    assign fill_way_tag[w] = tag_q[fill_set][w];
    assign fill_way_st[w]  = st_q[fill_set][w];
  end

  logic fill_hit, fill_hit_way;

  tag_dir_lookup #(.TAG_W(TAG_W)) u_lk_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tag_i     (lk_tag),
    .way_tag_i (lk_way_tag),
    .way_st_i  (lk_way_st),
    .hit_o     (lk_hit_o),
    .way_o     (lk_way_o)
  );

  tag_dir_lookup #(.TAG_W(TAG_W)) u_fill_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tag_i     (fill_tag),
    .way_tag_i (fill_way_tag),
    .way_st_i  (fill_way_st),
    .hit_o     (fill_hit),
    .way_o     (fill_hit_way)
  );

  tag_dir_victim #(.TAG_W(TAG_W)) u_victim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .way_tag_i (fill_way_tag),
    .way_st_i  (fill_way_st),
    .lru_i     (lru_q[fill_set]),
    .hit_i     (fill_hit),
    .hit_way_i (fill_hit_way),
    .way_o     (fill_way_o),
    .wb_o      (fill_wb_o),
    .vtag_o    (fill_victim_tag_o)
  );

  assign lk_state_o = lk_hit_o ? lk_way_st[lk_way_o] : ST_I;

  logic upd_blocked;
  assign upd_blocked = fill_valid_i && (upd_set_i == fill_set) && (upd_way_i == fill_way_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        lru_q[s] <= 1'b0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          st_q[s][w]  <= ST_I;
        end
      end
    end else begin
      if (upd_valid_i && !upd_blocked)
        st_q[upd_set_i][upd_way_i] <= line_state_e'(upd_state_i);
      if (lk_valid_i && lk_hit_o)
        lru_q[lk_set] <= ~lk_way_o;
      // fill last: its recency value wins on a shared set
      if (fill_valid_i) begin
        tag_q[fill_set][fill_way_o] <= fill_tag;
        st_q[fill_set][fill_way_o]  <= line_state_e'(fill_state_i);
        lru_q[fill_set]             <= ~fill_way_o;
      end
    end
  end

  assert_fill_commit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(fill_valid_i)) |->
      (tag_q[$past(fill_set)][$past(fill_way_o)] == $past(fill_tag) &&
       st_q[$past(fill_set)][$past(fill_way_o)] == $past(fill_state_i)));

  assert_fill_lru_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(fill_valid_i)) |->
      (lru_q[$past(fill_set)] == !$past(fill_way_o)));

  assert_upd_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(upd_valid_i) && !$past(upd_blocked)) |->
      (st_q[$past(upd_set_i)][$past(upd_way_i)] == $past(upd_state_i)));
endmodule

// File: tb/tag_dir_bench.sv
`timescale 1ns/1ps
module tag_dir_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid_i = 1'b0;
  logic [31:0] lk_addr_i = '0;
  logic        lk_hit_o, lk_way_o;
  logic [1:0]  lk_state_o;
  logic        fill_valid_i = 1'b0;
  logic [31:0] fill_addr_i = '0;
  logic [1:0]  fill_state_i = '0;
  logic        fill_way_o, fill_wb_o;
  logic [19:0] fill_victim_tag_o;
  logic        upd_valid_i = 1'b0;
  logic [3:0]  upd_set_i = '0;
  logic        upd_way_i = 1'b0;
  logic [1:0]  upd_state_i = '0;

  int checks = 0;
  int failures = 0;

  always #10 clk_i = ~clk_i;

  tag_dir u_tag_dir (
    .clk_i, .rst_ni, .lk_valid_i, .lk_addr_i, .lk_hit_o, .lk_way_o, .lk_state_o,
    .fill_valid_i, .fill_addr_i, .fill_state_i, .fill_way_o, .fill_wb_o,
    .fill_victim_tag_o, .upd_valid_i, .upd_set_i, .upd_way_i, .upd_state_i
  );

  // reference model
  logic [19:0] m_tag [16][2];
  logic [1:0]  m_st  [16][2];
  logic        m_lru [16];

  function automatic logic [31:0] mk(input logic [19:0] t, input logic [3:0] s, input logic [7:0] o);
    return {t, s, o};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_find(input logic [31:0] a, output logic hit, output logic way);
    logic [3:0] s = a[11:8];
    hit = 1'b0; way = 1'b0;
    for (int w = 0; w < 2; w++)
      if (m_st[s][w] != 2'b00 && m_tag[s][w] == a[31:12]) begin hit = 1'b1; way = w[0]; end
  endtask

  task automatic m_pick(input logic [31:0] a, output logic way, output logic wb, output logic hit);
    logic [3:0] s = a[11:8];
    logic hw;
    m_find(a, hit, hw);
    if (hit) way = hw;
    else if (m_st[s][0] == 2'b00) way = 1'b0;
    else if (m_st[s][1] == 2'b00) way = 1'b1;
    else way = m_lru[s];
    wb = !hit && m_st[s][way] == 2'b11;
  endtask

  task automatic do_lookup(input string req, input logic [31:0] a, input logic touch);
    logic h, w;
    @(negedge clk_i);
    lk_addr_i = a; lk_valid_i = touch;
    #2;
    m_find(a, h, w);
    chk({req, " hit"}, {31'd0, lk_hit_o}, {31'd0, h});
    if (h) begin
      chk({req, " way"}, {31'd0, lk_way_o}, {31'd0, w});
      chk({req, " state"}, {30'd0, lk_state_o}, {30'd0, m_st[a[11:8]][w]});
    end else
      chk({req, " miss state"}, {30'd0, lk_state_o}, 32'd0);
    @(posedge clk_i); #1;
    if (touch && h) m_lru[a[11:8]] = ~w;
    lk_valid_i = 1'b0;
  endtask

  task automatic do_fill(input string req, input logic [31:0] a, input logic [1:0] st,
                         input logic uv, input logic [3:0] us, input logic uw, input logic [1:0] ust);
    logic w, wb, h;
    logic [3:0] s = a[11:8];
    @(negedge clk_i);
    fill_addr_i = a; fill_state_i = st; fill_valid_i = 1'b1;
    upd_valid_i = uv; upd_set_i = us; upd_way_i = uw; upd_state_i = ust;
    #2;
    m_pick(a, w, wb, h);
    chk({req, " fill way"}, {31'd0, fill_way_o}, {31'd0, w});
    chk({req, " wb"}, {31'd0, fill_wb_o}, {31'd0, wb});
    if (wb) chk({req, " victim tag"}, {12'd0, fill_victim_tag_o}, {12'd0, m_tag[s][w]});
    @(posedge clk_i); #1;
    if (uv && !(us == s && uw == w)) m_st[us][uw] = ust;
    m_tag[s][w] = a[31:12]; m_st[s][w] = st; m_lru[s] = ~w;
    fill_valid_i = 1'b0; upd_valid_i = 1'b0;
  endtask

  task automatic do_upd(input logic [3:0] us, input logic uw, input logic [1:0] ust);
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_set_i = us; upd_way_i = uw; upd_state_i = ust;
    @(posedge clk_i); #1;
    m_st[us][uw] = ust;
    upd_valid_i = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int s = 0; s < 16; s++) begin
      m_lru[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin m_tag[s][w] = '0; m_st[s][w] = 2'b00; end
    end
    #45 rst_ni = 1'b1;

    // R1: all sets empty after reset
    for (int s = 0; s < 16; s++)
      do_lookup("R1 reset miss", mk(20'h00000 + 20'(s * 4099), 4'(s), 8'(s * 7)), 1'b1);

    // R4: two fills land in way 0 then way 1; R10 visible next cycle
    for (int s = 0; s < 16; s++) begin
      do_fill("R4 first", mk(20'h0A000 + 20'(s), 4'(s), 8'h00), 2'b10, 1'b0, 4'd0, 1'b0, 2'b00);
      do_lookup("R10 after fill", mk(20'h0A000 + 20'(s), 4'(s), 8'h00), 1'b0);
      do_fill("R4 second", mk(20'h0B000 + 20'(s), 4'(s), 8'h00), 2'b11, 1'b0, 4'd0, 1'b0, 2'b00);
    end

    // R2 R3: offset ignored; R5 touch on even sets only
    for (int s = 0; s < 16; s++) begin
      do_lookup("R2 offset", mk(20'h0A000 + 20'(s), 4'(s), 8'(s * 13 + 5)), s[0] == 1'b0);
      do_lookup("R3 modified hit", mk(20'h0B000 + 20'(s), 4'(s), 8'hFF), 1'b0);
    end

    // R5 R6: victim by recency, writeback only for Modified
    for (int s = 0; s < 16; s++)
      do_fill("R5 R6 evict", mk(20'h0C000 + 20'(s), 4'(s), 8'h10), 2'b01, 1'b0, 4'd0, 1'b0, 2'b00);

    // R2: same tag in a neighbouring set does not hit
    for (int s = 0; s < 16; s++)
      do_lookup("R2 other set", mk(20'h0C000 + 20'(s), 4'((s + 1) % 16), 8'h00), 1'b0);

    // R8 R3: invalidate via update, then promote the other way
    for (int s = 0; s < 16; s++) begin
      logic h, w;
      m_find(mk(20'h0C000 + 20'(s), 4'(s), 8'h00), h, w);
      do_upd(4'(s), w, 2'b00);
      do_lookup("R3 invalid no hit", mk(20'h0C000 + 20'(s), 4'(s), 8'h00), 1'b0);
      do_upd(4'(s), ~w, 2'b11);
      do_lookup("R8 update state", mk(20'h0C000 + 20'(s), 4'(s), 8'h00), 1'b0);
      do_lookup("R8 tag kept", mk(m_tag[s][~w], 4'(s), 8'h00), 1'b0);
    end

    // R7: refill of a resident Modified line reuses its way, no writeback
    for (int s = 0; s < 16; s++) begin
      do_fill("R7 reuse", mk(m_tag[s][m_st[s][1] == 2'b11], 4'(s), 8'h00), 2'b01,
              1'b0, 4'd0, 1'b0, 2'b00);
      do_lookup("R7 after reuse", mk(m_tag[s][m_lru[s] ^ 1'b1], 4'(s), 8'h00), 1'b0);
    end

    // R9: fill and update on the same entry; update elsewhere still applies
    for (int s = 0; s < 16; s++) begin
      logic w, wb, h;
      m_pick(mk(20'h0D000 + 20'(s), 4'(s), 8'h00), w, wb, h);
      do_fill("R9 same entry", mk(20'h0D000 + 20'(s), 4'(s), 8'h00), 2'b10, 1'b1, 4'(s), w, 2'b00);
      do_lookup("R9 fill kept", mk(20'h0D000 + 20'(s), 4'(s), 8'h00), 1'b0);
      do_fill("R9 other entry", mk(20'h0E000 + 20'(s), 4'(s), 8'h00), 2'b01,
              1'b1, 4'((s + 3) % 16), 1'b0, 2'b11);
      do_lookup("R9 other applied", mk(m_tag[(s + 3) % 16][0], 4'((s + 3) % 16), 8'h00), 1'b0);
    end

    // R5: fill and touching lookup on the same set in one cycle, fill wins
    @(negedge clk_i);
    lk_addr_i = mk(20'h0E005, 4'd5, 8'h00); lk_valid_i = 1'b1;
    fill_addr_i = mk(20'h0F005, 4'd5, 8'h00); fill_state_i = 2'b10; fill_valid_i = 1'b1;
    #2;
    begin
      logic w, wb, h;
      m_pick(fill_addr_i, w, wb, h);
      chk("R5 concurrent way", {31'd0, fill_way_o}, {31'd0, w});
      @(posedge clk_i); #1;
      m_tag[5][w] = 20'h0F005; m_st[5][w] = 2'b10; m_lru[5] = ~w;
    end
    lk_valid_i = 1'b0; fill_valid_i = 1'b0;
    do_fill("R5 after concurrent", mk(20'h01005, 4'd5, 8'h00), 2'b01, 1'b0, 4'd0, 1'b0, 2'b00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule